// File: doc/BRIEF.md
# Linear CCD Drive Clock Sequencer

This block produces every digital drive clock for a two-output color linear CCD whose two photodiode rows sit one line apart. The clocks are a two-phase transfer pair, a per-pixel reset strobe, two shift-gate pulses and a vertical transfer pulse. It runs from a fast system clock. Every pulse width, setup gap, hold gap and the transfer half-period is given as an input count of system-clock ticks. A count below its floor is raised to that floor.

A line begins on a `start` strobe while the block is idle, or on each wrap of a free-running integration counter when `free_run` is set. The block first runs a shift window in which the gate pulses fire. The first gate and the vertical pulse always share edges. `delay_mode` chooses where the second gate falls relative to them. In direct readout the second gate follows the first gate. In delay-memory readout it precedes the first gate and the vertical pulse. After a hold gap a fixed burst of transfer periods runs, each with one reset strobe. A one-cycle `line_done` strobe closes the line. All timing inputs and the mode are captured when the line starts.

Top module: `ccd_line_sequencer`

## Requirements
- R1: After reset, `phi1`=1 and `phi2`, `phi_rst`, `sg1`, `sg2`, `vt`, `busy` and `line_done` are all 0.
- R2: `sg1` and `vt` are equal in every cycle, so they rise and fall on the same system-clock edge.
- R3: With `delay_mode`=0, `sg1`/`vt` are high for W ticks from the first shift cycle. `sg2` rises S ticks after them and stays high for W ticks. The shift window lasts S+W+H ticks.
- R4: With `delay_mode`=1, `sg2` is high for W ticks from the first shift cycle. `sg1`/`vt` rise W+S ticks after `sg2` rises and stay high for W ticks. The shift window lasts 2W+S+H ticks.
- R5: `phi1` and `phi2` are never high together. While the block is idle, or while any gate is high, `phi1`=1 and `phi2`=0.
- R6: Each line has exactly LINE_PERIODS transfer periods (default 1048, which must exceed 1046). Each period is 2·HP ticks: `phi2` is high for the first HP ticks and `phi1` for the last HP ticks.
- R7: `phi_rst` pulses once per transfer period, for R ticks starting at the first tick of the period. It is high only while `phi2` is high.
- R8: Clamping: W is at least 4, S at least 2, H at least 1, HP at least 2 and R at least 1. R is also limited to at most HP.
- R9: `line_done` is high for exactly one cycle. That cycle follows the last tick of the last period and comes shift-window + LINE_PERIODS·2·HP cycles after the first shift cycle. `busy` is low in that cycle.
- R10: A `start` pulse while `busy` is ignored: no extra gate pulse, no change in line length.
- R11: With `free_run`=1, lines start every `integ_ticks` cycles, counted by a counter that runs from reset, provided each line ends within that interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Line start request, sampled only while idle |
| free_run | input | 1 | Start lines on integration counter wrap |
| delay_mode | input | 1 | 0: direct readout, 1: readout through delay memory |
| integ_ticks | input | IW | Free-run line interval in ticks |
| gate_ticks | input | TW | Gate pulse width W |
| setup_ticks | input | TW | Setup gap S |
| hold_ticks | input | TW | Hold gap H before transfers |
| half_ticks | input | TW | Transfer half-period HP |
| rst_ticks | input | TW | Reset strobe width R |
| phi1 | output | 1 | Transfer clock phase 1 |
| phi2 | output | 1 | Transfer clock phase 2 |
| phi_rst | output | 1 | Output reset strobe |
| sg1 | output | 1 | First shift gate |
| sg2 | output | 1 | Second shift gate |
| vt | output | 1 | Vertical transfer pulse |
| line_done | output | 1 | One-cycle end-of-line strobe |
| busy | output | 1 | Line in progress |

## Verification
Two events can land in the same cycle: a `start` request and a line already in progress (from an earlier start or a free-run wrap). The bench provokes this by pulsing `start` in the middle of a transfer burst. It then checks that exactly one gate pulse and one `line_done` appear, and that the done strobe keeps the exact cycle offset of an undisturbed line. In the same way, the last tick of a transfer period and the first tick of the next one meet on one edge. Reset strobe counts and `phi2` high-time totals must match LINE_PERIODS exactly, with no strobe outside a `phi2` half.

// File: rtl/ccd_line_sequencer.sv
module ccd_line_sequencer #(
  parameter int TW           = 16,
  parameter int IW           = 24,
  parameter int LINE_PERIODS = 1048,
  parameter int MIN_GATE     = 4,
  parameter int MIN_SETUP    = 2,
  parameter int MIN_HOLD     = 1,
  parameter int MIN_HALF     = 2,
  parameter int MIN_RST      = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          free_run,
  input  logic          delay_mode,
  input  logic [IW-1:0] integ_ticks,
  input  logic [TW-1:0] gate_ticks,
  input  logic [TW-1:0] setup_ticks,
  input  logic [TW-1:0] hold_ticks,
  input  logic [TW-1:0] half_ticks,
  input  logic [TW-1:0] rst_ticks,
  output logic          phi1,
  output logic          phi2,
  output logic          phi_rst,
  output logic          sg1,
  output logic          sg2,
  output logic          vt,
  output logic          line_done,
  output logic          busy
);
  localparam int SW = TW + 2;
  localparam int PW = $clog2(LINE_PERIODS + 1);

  typedef enum logic [1:0] {IDLE, SHIFT, XFER} state_t;

  function automatic logic [TW-1:0] floor_at(input logic [TW-1:0] v, input int m);
    return (v < TW'(m)) ? TW'(m) : v;
  endfunction

  state_t        st_q;
  logic          mode_q;
  logic [TW-1:0] w_q, s_q, h_q, hp_q, r_q;
  logic [SW-1:0] t_q;
  logic [TW:0]   hc_q;
  logic [PW-1:0] pc_q;
  logic          done_q;
  logic [IW-1:0] ic_q;

  logic [TW-1:0] hp_in, r_in;
  assign hp_in = floor_at(half_ticks, MIN_HALF);
  assign r_in  = (floor_at(rst_ticks, MIN_RST) > hp_in) ? hp_in : floor_at(rst_ticks, MIN_RST);

  logic wrap, trig;
  assign wrap = (integ_ticks == '0) || (ic_q >= integ_ticks - IW'(1));
  assign trig = (st_q == IDLE) && (start || (free_run && wrap));

  logic [SW-1:0] w_x, s_x, h_x, shift_end;
  assign w_x = SW'(w_q);
  assign s_x = SW'(s_q);
  assign h_x = SW'(h_q);
  assign shift_end = mode_q ? (w_x + w_x + s_x + h_x) : (s_x + w_x + h_x);

  logic shift_last, per_last, line_last;
  assign shift_last = (t_q == shift_end - SW'(1));
  assign per_last   = (hc_q == {hp_q, 1'b0} - (TW+1)'(1));
  assign line_last  = per_last && (pc_q == PW'(LINE_PERIODS - 1));

  logic early_win, late_win, first_gate, second_gate;
  assign early_win   = t_q < w_x;
  assign late_win    = (t_q >= (mode_q ? w_x + s_x : s_x)) &&
                       (t_q < (mode_q ? w_x + w_x + s_x : s_x + w_x));
  assign first_gate  = mode_q ? late_win : early_win;
  assign second_gate = mode_q ? early_win : late_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ic_q <= '0;
    else if (wrap) ic_q <= '0;
    else ic_q <= ic_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= IDLE;
      mode_q <= 1'b0;
      w_q    <= TW'(MIN_GATE);
      s_q    <= TW'(MIN_SETUP);
      h_q    <= TW'(MIN_HOLD);
      hp_q   <= TW'(MIN_HALF);
      r_q    <= TW'(MIN_RST);
      t_q    <= '0;
      hc_q   <= '0;
      pc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        IDLE: if (trig) begin
          st_q   <= SHIFT;
          mode_q <= delay_mode;
          w_q    <= floor_at(gate_ticks, MIN_GATE);
          s_q    <= floor_at(setup_ticks, MIN_SETUP);
          h_q    <= floor_at(hold_ticks, MIN_HOLD);
          hp_q   <= hp_in;
          r_q    <= r_in;
          t_q    <= '0;
        end
        SHIFT: begin
          if (shift_last) begin
            st_q <= XFER;
            hc_q <= '0;
            pc_q <= '0;
          end else begin
            t_q <= t_q + SW'(1);
          end
        end
        XFER: begin
          if (line_last) begin
            st_q   <= IDLE;
            done_q <= 1'b1;
          end else if (per_last) begin
            hc_q <= '0;
            pc_q <= pc_q + PW'(1);
          end else begin
            hc_q <= hc_q + (TW+1)'(1);
          end
        end
        default: st_q <= IDLE;
      endcase
    end
  end

  assign sg1       = (st_q == SHIFT) && first_gate;
  assign vt        = (st_q == SHIFT) && first_gate;
  assign sg2       = (st_q == SHIFT) && second_gate;
  assign phi2      = (st_q == XFER) && (hc_q < {1'b0, hp_q});
  assign phi1      = !phi2;
  assign phi_rst   = (st_q == XFER) && (hc_q < {1'b0, r_q});
  assign busy      = (st_q != IDLE);
  assign line_done = done_q;
endmodule

// File: rtl/ccd_line_sequencer_chk.sv
module ccd_line_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic phi1,
  input logic phi2,
  input logic phi_rst,
  input logic sg1,
  input logic sg2,
  input logic vt,
  input logic line_done,
  input logic busy
);
  assert_gate_vt_same_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sg1 == vt);
  assert_phase_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi1 && phi2));
  assert_phase_parked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sg1 || sg2 || !busy) |-> (phi1 && !phi2));
  assert_reset_in_phi2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    phi_rst |-> phi2);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);
  assert_done_ends_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (!busy && $past(busy)));
endmodule

bind ccd_line_sequencer ccd_line_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2), .phi_rst(phi_rst),
  .sg1(sg1), .sg2(sg2), .vt(vt), .line_done(line_done), .busy(busy)
);

// File: tb/ccd_line_sequencer_bench.sv
module ccd_line_sequencer_bench;
  localparam int TW = 16;
  localparam int IW = 24;
  localparam int NP = 1048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, free_run = 1'b0, delay_mode = 1'b0;
  logic [IW-1:0] integ_ticks = '0;
  logic [TW-1:0] gate_ticks = '0, setup_ticks = '0, hold_ticks = '0, half_ticks = '0, rst_ticks = '0;
  logic phi1, phi2, phi_rst, sg1, sg2, vt, line_done, busy;

  always #2.5 clk = ~clk;

  ccd_line_sequencer u_ccd_line_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .free_run(free_run), .delay_mode(delay_mode),
    .integ_ticks(integ_ticks), .gate_ticks(gate_ticks), .setup_ticks(setup_ticks),
    .hold_ticks(hold_ticks), .half_ticks(half_ticks), .rst_ticks(rst_ticks),
    .phi1(phi1), .phi2(phi2), .phi_rst(phi_rst), .sg1(sg1), .sg2(sg2), .vt(vt),
    .line_done(line_done), .busy(busy)
  );

  int tests = 0, fails = 0;
  logic mon_clr = 1'b0;
  int cyc, sg1_r1, sg1_r2, sg2_r, vt_r, sg1_hi, sg2_hi, phi2_hi, phi2_rises;
  int rst_hi, rst_rises, sg1_rises, done_cnt, done_cyc, vt_err, ph_err, park_err, rst_err;
  logic p_sg1, p_sg2, p_vt, p_phi2, p_rst;

  always @(negedge clk) begin
    if (mon_clr) begin
      cyc = 0; sg1_r1 = -1; sg1_r2 = -1; sg2_r = -1; vt_r = -1;
      sg1_hi = 0; sg2_hi = 0; phi2_hi = 0; phi2_rises = 0; rst_hi = 0; rst_rises = 0;
      sg1_rises = 0; done_cnt = 0; done_cyc = -1; vt_err = 0; ph_err = 0; park_err = 0; rst_err = 0;
      p_sg1 = 0; p_sg2 = 0; p_vt = 0; p_phi2 = 0; p_rst = 0;
    end else begin
      cyc++;
      if (sg1 && !p_sg1) begin
        if (sg1_rises == 0) sg1_r1 = cyc; else if (sg1_rises == 1) sg1_r2 = cyc;
        sg1_rises++;
      end
      if (sg2 && !p_sg2) sg2_r = cyc;
      if (vt && !p_vt) vt_r = cyc;
      if (phi2 && !p_phi2) phi2_rises++;
      if (phi_rst && !p_rst) rst_rises++;
      if (sg1) sg1_hi++;
      if (sg2) sg2_hi++;
      if (phi2) phi2_hi++;
      if (phi_rst) rst_hi++;
      if (line_done) begin done_cnt++; done_cyc = cyc; if (busy) ph_err++; end
      if (sg1 != vt) vt_err++;
      if (phi1 == phi2) ph_err++;
      if ((sg1 || sg2 || !busy) && !(phi1 && !phi2)) park_err++;
      if (phi_rst && !phi2) rst_err++;
      p_sg1 = sg1; p_sg2 = sg2; p_vt = vt; p_phi2 = phi2; p_rst = phi_rst;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic setup(input bit mode, input int w, input int s, input int h, input int hp, input int r);
    @(negedge clk);
    delay_mode = mode; gate_ticks = TW'(w); setup_ticks = TW'(s);
    hold_ticks = TW'(h); half_ticks = TW'(hp); rst_ticks = TW'(r);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    wait (done_cnt > 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(phi1 && !phi2 && !phi_rst, "R1 phases", {phi1, phi2, phi_rst}, 3'b100);
    check(!sg1 && !sg2 && !vt, "R1 gates", {sg1, sg2, vt}, 0);
    check(!busy && !line_done, "R1 status", {busy, line_done}, 0);
  endtask

  task automatic t_direct();
    setup(0, 6, 2, 3, 3, 2);
    clear_mon();
    pulse_start();
    wait_done();
    check(vt_err == 0 && vt_r == sg1_r1, "R2 sg1/vt edges", vt_r, sg1_r1);
    check(sg2_r - sg1_r1 == 2, "R3 sg2 offset", sg2_r - sg1_r1, 2);
    check(sg1_hi == 6 && sg2_hi == 6, "R3 widths", sg1_hi * 100 + sg2_hi, 606);
    check(ph_err == 0 && park_err == 0, "R5 phase rules", ph_err + park_err, 0);
    check(phi2_rises == NP && phi2_hi == NP * 3, "R6 periods", phi2_hi, NP * 3);
    check(rst_rises == NP && rst_hi == NP * 2 && rst_err == 0, "R7 reset strobe", rst_hi, NP * 2);
    check(done_cnt == 1 && done_cyc - sg1_r1 == 11 + NP * 6, "R9 done timing", done_cyc - sg1_r1, 11 + NP * 6);
  endtask

  task automatic t_delay();
    setup(1, 5, 3, 2, 2, 1);
    clear_mon();
    pulse_start();
    wait_done();
    check(vt_r - sg2_r == 8 && vt_r == sg1_r1, "R4 vt after sg2", vt_r - sg2_r, 8);
    check(sg1_hi == 5 && sg2_hi == 5, "R4 widths", sg1_hi * 100 + sg2_hi, 505);
    check(vt_err == 0, "R2 sg1/vt edges delay mode", vt_err, 0);
    check(done_cyc - sg2_r == 15 + NP * 4, "R4 window length", done_cyc - sg2_r, 15 + NP * 4);
    check(rst_hi == NP && rst_err == 0 && park_err == 0, "R7 reset strobe delay mode", rst_hi, NP);
  endtask

  task automatic t_clamp();
    setup(0, 0, 0, 0, 0, 9);
    clear_mon();
    pulse_start();
    wait_done();
    check(sg1_hi == 4, "R8 gate floor", sg1_hi, 4);
    check(sg2_r - sg1_r1 == 2, "R8 setup floor", sg2_r - sg1_r1, 2);
    check(phi2_hi == NP * 2, "R8 half floor", phi2_hi, NP * 2);
    check(rst_hi == NP * 2, "R8 reset limited to half", rst_hi, NP * 2);
    check(done_cyc - sg1_r1 == 7 + NP * 4, "R8 hold floor", done_cyc - sg1_r1, 7 + NP * 4);
  endtask

  task automatic t_midline_start();
    setup(0, 6, 2, 3, 3, 2);
    clear_mon();
    pulse_start();
    repeat (3000) @(negedge clk);
    pulse_start();
    wait_done();
    repeat (30) @(negedge clk);
    check(sg1_rises == 1, "R10 no extra gate", sg1_rises, 1);
    check(done_cnt == 1, "R10 single done", done_cnt, 1);
    check(done_cyc - sg1_r1 == 11 + NP * 6, "R10 length kept", done_cyc - sg1_r1, 11 + NP * 6);
  endtask

  task automatic t_free_run();
    setup(0, 4, 2, 1, 2, 1);
    @(negedge clk); integ_ticks = IW'(4400);
    clear_mon();
    @(negedge clk); free_run = 1'b1;
    wait (sg1_rises >= 2);
    @(negedge clk); free_run = 1'b0;
    check(sg1_r2 - sg1_r1 == 4400, "R11 free-run interval", sg1_r2 - sg1_r1, 4400);
    wait (!busy);
    repeat (4) @(negedge clk);
    check(done_cnt == 2, "R11 lines completed", done_cnt, 2);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_mon();
    t_reset();
    t_direct();
    t_delay();
    t_clamp();
    t_midline_start();
    t_free_run();
    finish_run();
  end
endmodule